// File: doc/BRIEF.md
# Per-Bit Read Eye Centering Engine

This block calibrates the read path of one byte lane. After a start pulse it points the memory at its fixed readback pattern register, so that no write has to come first. It then walks the read delay code from zero to the top of its range. For each code it issues one read and checks every returned bit against the known alternating pattern, beat by beat. Each data bit keeps its own record of where its passing window begins and ends.

When the sweep is over, each bit's delay output is loaded with the midpoint of that bit's own window. The skew between the bits that share a strobe is therefore corrected bit by bit, not with one delay for the whole lane. A bit that never passed is flagged in an error mask and given delay zero. During the sweep the trial code is presented on a separate output. The trained delay outputs change only once, in the cycle in which `done` rises.

Top module: `rbc_eye_center`

## Requirements
- R1: After reset, `done`, `rd_req`, `mpr_sel`, every `dly_code` field and every `err_mask` bit are 0.
- R2: `mpr_sel` is high from the cycle after an accepted `start` until training completes, and `rd_req` is only asserted while `mpr_sel` is high.
- R3: One training run issues exactly 128 single-cycle `rd_req` pulses, with `sweep_code` equal to 0, 1, 2 and so on up to 127 in ascending order.
- R4: The expected value on beat k of a burst is bit (k mod 8) of the pattern 0x55, the same for every data bit, so beat 0 expects 1 and beat 1 expects 0. A code passes for a bit only if all 8 beats of that bit match.
- R5: Each of the 8 bits is judged and centred independently, from the same shared reads.
- R6: Only the first contiguous run of passing codes counts. Passing codes after the first failure that ends that run are ignored.
- R7: A bit's trained delay is floor((first passing code + last passing code of the run) / 2). Bit i occupies `dly_code[7*i +: 7]`.
- R8: A bit with no passing code sets `err_mask[i]` and receives delay 0.
- R9: The `dly_code` and `err_mask` outputs keep their previous values during training and all update in the cycle in which `done` rises. `done` is a one-cycle pulse.
- R10: A `start` that arrives while training is running is ignored. It neither restarts nor extends the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a training run when idle |
| done | output | 1 | One-cycle pulse when results are loaded |
| mpr_sel | output | 1 | Selects the fixed readback pattern register for the duration of training |
| rd_req | output | 1 | One-cycle read request, one per trial code |
| sweep_code | output | 7 | Trial delay code applied to all bits during the sweep |
| rd_valid | input | 1 | Qualifies one beat of returned read data |
| rd_dq | input | 8 | Returned data bits, one per lane bit |
| dly_code | output | 56 | Trained delay per bit, 7 bits each, bit i at [7*i +: 7] |
| err_mask | output | 8 | Set for each bit that found no passing code |

## Verification
The bench gives each bit its own window of good codes. Failing codes are corrupted on a single beat only, so a design that checked only some beats of the burst would accept bad codes. Windows are placed at code 0, at code 127, across the full range, one code wide and entirely absent, which exposes off-by-one and overflow faults in the midpoint and in the sweep limit. A second passing window placed after a gap would drag the centre upward in a design that kept extending the run. Outputs are sampled in the middle of a run, with a stray start pulse, to catch early updates or a restarted sweep.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL,
    ST_CENTER
  } rbc_state_e;

  // expected value of a data bit on a given beat of the readback burst
  function automatic logic exp_bit(input logic [7:0] pat, input int beat);
    return pat[beat % 8];
  endfunction

  // floor of the average of two codes, without losing the carry
  function automatic logic [15:0] mid_code(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[16:1];
  endfunction

endpackage

// File: rtl/rbc_sweep_seq.sv
module rbc_sweep_seq
  import rbc_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int BEATS  = 8,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_valid,
  output logic              begin_run,
  output logic              issue,
  output logic              beat_we,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              eval,
  output logic              load,
  output logic              active,
  output logic              done,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BEATS - 1);

  rbc_state_e        state_q;
  logic [CODE_W-1:0] code_q;
  logic [BEAT_W-1:0] beat_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_CENTER);
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_ISSUE;
            code_q  <= '0;
          end
        end
        ST_ISSUE: begin
          state_q <= ST_WAIT;
          beat_q  <= '0;
        end
        ST_WAIT: begin
          if (rd_valid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == BEAT_LAST) state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (code_q == CODE_MAX) begin
            state_q <= ST_CENTER;
          end else begin
            code_q  <= code_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_CENTER: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign begin_run = (state_q == ST_IDLE) && start;
  assign issue     = (state_q == ST_ISSUE);
  assign beat_we   = (state_q == ST_WAIT) && rd_valid;
  assign beat_idx  = beat_q;
  assign eval      = (state_q == ST_EVAL);
  assign load      = (state_q == ST_CENTER);
  assign active    = (state_q != ST_IDLE);
  assign done      = done_q;
  assign code      = code_q;

endmodule

// File: rtl/rbc_bit_track.sv
module rbc_bit_track
  import rbc_pkg::*;
#(
  parameter int          CODE_W  = 7,
  parameter int          BEATS   = 8,
  parameter logic [7:0]  PATTERN = 8'h55,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_run,
  input  logic              clr_acc,
  input  logic              beat_we,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic              dq,
  input  logic              eval,
  input  logic [CODE_W-1:0] code,
  output logic              pass_evt,
  output logic              none,
  output logic [CODE_W-1:0] centre
);

  logic              miss_q;
  logic              found_q;
  logic              closed_q;
  logic [CODE_W-1:0] first_q;
  logic [CODE_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q   <= 1'b0;
      found_q  <= 1'b0;
      closed_q <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
    end else begin
      if (begin_run) begin
        found_q  <= 1'b0;
        closed_q <= 1'b0;
        first_q  <= '0;
        last_q   <= '0;
      end else if (eval) begin
        if (!miss_q) begin
          if (!found_q) begin
            found_q <= 1'b1;
            first_q <= code;
            last_q  <= code;
          end else if (!closed_q) begin
            last_q <= code;
          end
        end else if (found_q) begin
          closed_q <= 1'b1;
        end
      end

      if (clr_acc)
        miss_q <= 1'b0;
      else if (beat_we && (dq != exp_bit(PATTERN, int'(beat_idx))))
        miss_q <= 1'b1;
    end
  end

  assign pass_evt = eval && !miss_q;
  assign none     = !found_q;
  assign centre   = found_q ? CODE_W'(mid_code(16'(first_q), 16'(last_q))) : '0;

endmodule

// File: rtl/rbc_eye_center.sv
module rbc_eye_center #(
  parameter int         DQ_W    = 8,
  parameter int         CODE_W  = 7,
  parameter int         BEATS   = 8,
  parameter logic [7:0] PATTERN = 8'h55,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     done,
  output logic                     mpr_sel,
  output logic                     rd_req,
  output logic [CODE_W-1:0]        sweep_code,
  input  logic                     rd_valid,
  input  logic [DQ_W-1:0]          rd_dq,
  output logic [DQ_W*CODE_W-1:0]   dly_code,
  output logic [DQ_W-1:0]          err_mask
);

  // internal events, named for the checker
  logic              begin_run;
  logic              issue_stb;
  logic              beat_we;
  logic [BEAT_W-1:0] beat_idx;
  logic              eval_stb;
  logic              load_stb;
  logic              active;
  logic [DQ_W-1:0]   pass_vec;
  logic [DQ_W-1:0]   none_vec;
  logic [DQ_W*CODE_W-1:0] centre_vec;

  logic [DQ_W*CODE_W-1:0] dly_q;
  logic [DQ_W-1:0]        err_q;

  rbc_sweep_seq #(
    .CODE_W (CODE_W),
    .BEATS  (BEATS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_valid  (rd_valid),
    .begin_run (begin_run),
    .issue     (issue_stb),
    .beat_we   (beat_we),
    .beat_idx  (beat_idx),
    .eval      (eval_stb),
    .load      (load_stb),
    .active    (active),
    .done      (done),
    .code      (sweep_code)
  );

  for (genvar gi = 0; gi < DQ_W; gi++) begin : g_bit
    rbc_bit_track #(
      .CODE_W  (CODE_W),
      .BEATS   (BEATS),
      .PATTERN (PATTERN)
    ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .begin_run (begin_run),
      .clr_acc   (issue_stb),
      .beat_we   (beat_we),
      .beat_idx  (beat_idx),
      .dq        (rd_dq[gi]),
      .eval      (eval_stb),
      .code      (sweep_code),
      .pass_evt  (pass_vec[gi]),
      .none      (none_vec[gi]),
      .centre    (centre_vec[gi*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q <= '0;
      err_q <= '0;
    end else if (load_stb) begin
      dly_q <= centre_vec;
      err_q <= none_vec;
    end
  end

  assign dly_code = dly_q;
  assign err_mask = err_q;
  assign mpr_sel  = active;
  assign rd_req   = issue_stb;

endmodule

// File: rtl/rbc_eye_center_chk.sv
module rbc_eye_center_chk #(
  parameter int DQ_W   = 8,
  parameter int CODE_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   done,
  input logic                   mpr_sel,
  input logic                   rd_req,
  input logic [CODE_W-1:0]      sweep_code,
  input logic [DQ_W*CODE_W-1:0] dly_code,
  input logic [DQ_W-1:0]        err_mask,
  input logic [DQ_W-1:0]        pass_vec,
  input logic                   eval_stb,
  input logic                   load_stb
);

  logic [DQ_W-1:0]   zero_f;
  logic              seen_q;
  logic [CODE_W-1:0] last_code_q;

  for (genvar gi = 0; gi < DQ_W; gi++) begin : g_z
    assign zero_f[gi] = (dly_code[gi*CODE_W +: CODE_W] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      last_code_q <= '0;
    end else if (done) begin
      seen_q <= 1'b0;
    end else if (rd_req) begin
      seen_q      <= 1'b1;
      last_code_q <= sweep_code;
    end
  end

  AST_REQ_IN_MPR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> mpr_sel); // R2

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R3

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && seen_q) |-> (sweep_code == last_code_q + 1'b1)); // R3

  AST_PASS_AT_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_vec != '0) |-> eval_stb); // R5

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((err_mask & ~zero_f) == '0)); // R8

  AST_HOLD_DLY: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(dly_code) && $stable(err_mask))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (done && !mpr_sel)); // R2

endmodule

bind rbc_eye_center rbc_eye_center_chk #(
  .DQ_W   (DQ_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .mpr_sel    (mpr_sel),
  .rd_req     (rd_req),
  .sweep_code (sweep_code),
  .dly_code   (dly_code),
  .err_mask   (err_mask),
  .pass_vec   (pass_vec),
  .eval_stb   (eval_stb),
  .load_stb   (load_stb)
);

// File: tb/sim_rbc_eye_center.sv
`timescale 1ns/1ps
module sim_rbc_eye_center;

  localparam int NB = 8;
  localparam int CW = 7;
  localparam int BEATS = 8;
  localparam logic [7:0] PAT = 8'h55;
  localparam int NV = 5;

  // per-vector first window per bit; lo > hi means the bit never passes
  localparam int VLO [NV][NB] = '{
    '{10, 20, 30, 40, 50, 60, 70, 80},
    '{32, 32, 32, 32, 32, 32, 32, 32},
    '{ 0,127,  0,  5,  0,126,  1, 64},
    '{ 9,  9,  9,  9,  9,  9,  9,  3},
    '{ 1,  3,  5,  7,  9, 11, 13, 15}
  };
  localparam int VHI [NV][NB] = '{
    '{40, 45, 50, 55, 90,100,110,120},
    '{95, 95, 95, 95, 95, 95, 95, 95},
    '{ 0,127,127,  4,  1,127,  0, 65},
    '{ 1,  1,  1,  1,  1,  1,  1,  9},
    '{ 2,  6, 10, 20, 30, 40, 50,126}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, mpr_sel, rd_req;
  logic [CW-1:0] sweep_code;
  logic rd_valid = 1'b0;
  logic [NB-1:0] rd_dq = '0;
  logic [NB*CW-1:0] dly_code;
  logic [NB-1:0] err_mask;

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int seq_bad = 0;
  int win_lo [NB];
  int win_hi [NB];
  int w2_lo [NB];
  int w2_hi [NB];
  bit w2_en = 1'b0;
  int fail_beat = BEATS - 1;

  always #2.5 clk = ~clk;

  rbc_eye_center u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .mpr_sel(mpr_sel), .rd_req(rd_req), .sweep_code(sweep_code),
    .rd_valid(rd_valid), .rd_dq(rd_dq), .dly_code(dly_code),
    .err_mask(err_mask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic bit good(input int c, input int b);
    bit g;
    g = (c >= win_lo[b]) && (c <= win_hi[b]);
    if (w2_en && c >= w2_lo[b] && c <= w2_hi[b]) g = 1'b1;
    return g;
  endfunction

  function automatic int exp_mid(input int b);
    return (win_lo[b] <= win_hi[b]) ? (win_lo[b] + win_hi[b]) / 2 : 0;
  endfunction

  // memory model: answers each read with a burst; a bad code corrupts one beat
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        int c;
        c = int'(sweep_code);
        if (!mpr_sel || c != req_cnt) seq_bad++;
        req_cnt++;
        @(negedge clk);
        for (int k = 0; k < BEATS; k++) begin
          for (int b = 0; b < NB; b++) begin
            logic e;
            e = PAT[k % 8];
            rd_dq[b] = (!good(c, b) && k == fail_beat) ? ~e : e;
          end
          rd_valid = 1'b1;
          @(negedge clk);
        end
        rd_valid = 1'b0;
        rd_dq = '0;
      end
    end
  end

  task automatic kick();
    req_cnt = 0;
    seq_bad = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n;
    n = 0;
    ok = 1'b1;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 6000) begin
        ok = 1'b0;
        break;
      end
    end
  endtask

  task automatic check_results(input string tag);
    for (int b = 0; b < NB; b++) begin
      int a;
      a = int'(dly_code[b*CW +: CW]);
      chk(a == exp_mid(b), {tag, " R7 delay"}, a, exp_mid(b));
      chk(err_mask[b] == (win_lo[b] > win_hi[b]), {tag, " R8 err bit"},
          int'(err_mask[b]), int'(win_lo[b] > win_hi[b]));
    end
    chk(req_cnt == 128, {tag, " R3 read count"}, req_cnt, 128);
    chk(seq_bad == 0, {tag, " R3 R2 code order / mpr_sel"}, seq_bad, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 done pulse width"}, int'(done), 0);
    chk(mpr_sel == 1'b0, {tag, " R2 mpr_sel released"}, int'(mpr_sel), 0);
  endtask

  task automatic full_run(input string tag);
    bit ok;
    kick();
    wait_done(ok);
    chk(ok, {tag, " watchdog"}, int'(ok), 1);
    if (ok) check_results(tag);
  endtask

  initial begin
    bit ok;
    int prev_d [NB];
    logic [NB-1:0] prev_e;
    repeat (3) @(negedge clk);
    chk(done == 0 && rd_req == 0 && mpr_sel == 0, "R1 idle controls", int'({done, rd_req, mpr_sel}), 0);
    chk(dly_code == '0, "R1 delays zero", int'(dly_code[15:0]), 0);
    chk(err_mask == '0, "R1 error mask zero", int'(err_mask), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mpr_sel == 0 && rd_req == 0, "R1 idle after release", int'({mpr_sel, rd_req}), 0);

    // table walk: R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      for (int b = 0; b < NB; b++) begin
        win_lo[b] = VLO[v][b];
        win_hi[b] = VHI[v][b];
      end
      full_run($sformatf("vec%0d R5", v));
    end

    // R6: a second passing window after a failing gap is ignored
    for (int b = 0; b < NB; b++) begin
      win_lo[b] = 32; win_hi[b] = 95; w2_lo[b] = 105; w2_hi[b] = 120;
    end
    w2_en = 1'b1;
    full_run("R6 second window");
    w2_en = 1'b0;

    // R4: corruption on beat 0 only still fails the code
    fail_beat = 0;
    for (int b = 0; b < NB; b++) begin
      win_lo[b] = 40 + b; win_hi[b] = 70 + 3 * b;
    end
    full_run("R4 first-beat miss");
    fail_beat = BEATS - 1;

    // R9 / R10: outputs hold mid-run; a start while busy is ignored
    for (int b = 0; b < NB; b++) prev_d[b] = exp_mid(b);
    prev_e = err_mask;
    for (int b = 0; b < NB; b++) begin
      win_lo[b] = 5; win_hi[b] = 20 + 10 * b;
    end
    kick();
    repeat (400) @(negedge clk);
    chk(mpr_sel == 1'b1, "R2 mpr_sel during run", int'(mpr_sel), 1);
    for (int b = 0; b < NB; b++)
      chk(int'(dly_code[b*CW +: CW]) == prev_d[b], "R9 hold mid-run",
          int'(dly_code[b*CW +: CW]), prev_d[b]);
    chk(err_mask == prev_e, "R9 err hold mid-run", int'(err_mask), int'(prev_e));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(ok, "R10 watchdog", int'(ok), 1);
    if (ok) check_results("R10 start while busy");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog global timeout actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule